// File: doc/BRIEF.md
# Serial EEPROM configuration loader

This block runs once after reset. It fetches a short configuration image from an external serial EEPROM and decides whether the image can be trusted. It then presents the identifiers and port settings that the rest of a USB hub uses to build its descriptors. The block does not drive the EEPROM wires itself. It issues single-byte read requests to a serial master outside the block and waits for each response before it asks for the next byte.

The image is accepted only if all of these hold:
- the checksum matches;
- the port count is legal;
- the power figure is in range.

If any test fails, the whole image is discarded and a fixed set of defaults is published instead. A status bit shows which of the two sources the outputs came from.

Once loading is finished, the EEPROM request channel is handed to a pass-through port. Other logic, such as string-descriptor fetches, can then read arbitrary bytes through it.

Top module: `cfg_loader`

## Requirements
- R1: After reset the loader requests byte addresses 0, 1, 2 … 8 in increasing order, exactly nine requests, never raising a new request while an earlier one is still unanswered.
- R2: `config_valid` is 1 after loading exactly when all three tests pass: byte4 equals (byte0+byte1+byte2+byte3+1) mod 256; byte7 lies in 1..NUM_PORTS; byte8 is at most 0xFA.
- R3: For an accepted image, `vendor_id` = {byte1, byte0} and `product_id` = {byte3, byte2}.
- R4: For an accepted image, `fixed_mask[i]` = bit i+1 of byte6 (1 = device on port i+1 is non-removable). Bits 0, 5, 6 and 7 of byte6 have no effect on any output.
- R5: For an accepted image, `port_count` = byte7 and `max_power` = byte8 (units of 2 mA).
- R6: For a rejected image, `config_valid` = 0, `vendor_id` = 0x04B4, `product_id` = 0x6570, `fixed_mask` = 0 (all removable), `port_count` = NUM_PORTS and `max_power` = DEF_MAX_PWR (0x32 by default).
- R7: `done` and `config_valid` are 0 during reset. The published fields and `config_valid` take their final values one cycle before `done` rises. After that, `done` and all fields hold until the next reset.
- R8: Before `done`, `pt_req` is ignored: it produces no EEPROM request and `pt_rvalid` stays 0. After `done`, a `pt_req` issues an EEPROM read of `pt_addr`, and the response appears on `pt_rvalid`/`pt_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ee_req | output | 1 | One-cycle byte read request to the serial master |
| ee_addr | output | ADDR_W | Byte address of the request |
| ee_rvalid | input | 1 | One-cycle response strobe |
| ee_rdata | input | 8 | Response byte |
| pt_req | input | 1 | Pass-through read request (honoured after done) |
| pt_addr | input | ADDR_W | Pass-through byte address |
| pt_rvalid | output | 1 | Pass-through response strobe |
| pt_rdata | output | 8 | Pass-through response byte |
| config_valid | output | 1 | 1 = fields came from the EEPROM image |
| done | output | 1 | Loading finished; fields are final |
| vendor_id | output | 16 | Published vendor identifier |
| product_id | output | 16 | Published product identifier |
| fixed_mask | output | NUM_PORTS | Per-port non-removable flags |
| port_count | output | $clog2(NUM_PORTS+1) | Number of downstream ports |
| max_power | output | 8 | Bus current demand in 2 mA units |

## Verification
The assertions assume the serial master answers every request exactly once, a cycle or more later, and never strobes a response that nobody asked for. They also assume the pass-through user waits for its answer before asking again. The bench EEPROM model keeps a single pending flag and replies after a random delay of 1 to 4 cycles. The pass-through task waits for each response before it returns, so the traffic stays inside those assumptions. Images are drawn so that roughly half violate one of the acceptance tests, including both ends of the port-count and power ranges.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [1:0] {
        ST_REQ    = 2'd0,
        ST_WAIT   = 2'd1,
        ST_DECIDE = 2'd2,
        ST_DONE   = 2'd3
    } ld_state_e;

    localparam int IMG_BYTES = 9;

endpackage

// File: rtl/cfg_image_check.sv
module cfg_image_check #(
    parameter int          NUM_PORTS     = 4,
    parameter int          IMG_BYTES     = 9,
    parameter int          PCNT_W        = $clog2(NUM_PORTS + 1),
    parameter logic [7:0]  MAX_PWR_LIMIT = 8'hFA,
    parameter logic [15:0] DEF_VID       = 16'h04B4,
    parameter logic [15:0] DEF_PID       = 16'h6570,
    parameter logic [7:0]  DEF_MAX_PWR   = 8'h32
) (
    input  logic [IMG_BYTES-1:0][7:0] img,
    output logic                      accept,
    output logic [15:0]               vid,
    output logic [15:0]               pid,
    output logic [NUM_PORTS-1:0]      mask,
    output logic [PCNT_W-1:0]         pcnt,
    output logic [7:0]                mpw
);
    // byte positions inside the image
    localparam int IX_VID_LO = 0;
    localparam int IX_VID_HI = 1;
    localparam int IX_PID_LO = 2;
    localparam int IX_PID_HI = 3;
    localparam int IX_SUM    = 4;
    localparam int IX_SPARE  = 5;
    localparam int IX_FIXED  = 6;
    localparam int IX_PCNT   = 7;
    localparam int IX_MPW    = 8;

    logic [7:0]           sum_calc;
    logic                 sum_ok, pcnt_ok, mpw_ok;
    logic [NUM_PORTS-1:0] mask_img;
    logic                 spare_unused;

    assign sum_calc = img[IX_VID_LO] + img[IX_VID_HI] + img[IX_PID_LO] + img[IX_PID_HI] + 8'd1;
    assign sum_ok   = (img[IX_SUM] == sum_calc);
    assign pcnt_ok  = (img[IX_PCNT] != 8'd0) && (img[IX_PCNT] <= 8'(NUM_PORTS));
    assign mpw_ok   = (img[IX_MPW] <= MAX_PWR_LIMIT);
    assign accept   = sum_ok && pcnt_ok && mpw_ok;

    // port p+1 flag sits one bit above its index; bit 0 is reserved
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mask
        assign mask_img[p] = img[IX_FIXED][p+1];
    end

    assign vid  = accept ? {img[IX_VID_HI], img[IX_VID_LO]} : DEF_VID;
    assign pid  = accept ? {img[IX_PID_HI], img[IX_PID_LO]} : DEF_PID;
    assign mask = accept ? mask_img : '0;
    assign pcnt = accept ? img[IX_PCNT][PCNT_W-1:0] : PCNT_W'(NUM_PORTS);
    assign mpw  = accept ? img[IX_MPW] : DEF_MAX_PWR;

    assign spare_unused = ^{img[IX_SPARE], img[IX_FIXED], img[IX_PCNT]};

    always_comb begin
        if (accept) begin
            assert_accept_legal_R2: assert (pcnt != '0 && mpw <= MAX_PWR_LIMIT);
        end
    end

endmodule

// File: rtl/cfg_loader_seq.sv
module cfg_loader_seq
    import cfg_loader_pkg::*;
#(
    parameter int          NUM_PORTS   = 4,
    parameter int          IMG_BYTES   = 9,
    parameter int          IDX_W       = $clog2(IMG_BYTES),
    parameter int          PCNT_W      = $clog2(NUM_PORTS + 1),
    parameter logic [15:0] DEF_VID     = 16'h04B4,
    parameter logic [15:0] DEF_PID     = 16'h6570,
    parameter logic [7:0]  DEF_MAX_PWR = 8'h32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_rvalid,
    input  logic [7:0]                rd_rdata,
    output logic                      rd_req,
    output logic [IDX_W-1:0]          rd_idx,
    output logic [IMG_BYTES-1:0][7:0] img,
    input  logic                      chk_accept,
    input  logic [15:0]               chk_vid,
    input  logic [15:0]               chk_pid,
    input  logic [NUM_PORTS-1:0]      chk_mask,
    input  logic [PCNT_W-1:0]         chk_pcnt,
    input  logic [7:0]                chk_mpw,
    output logic                      cfg_valid,
    output logic                      ld_done,
    output logic [15:0]               vid,
    output logic [15:0]               pid,
    output logic [NUM_PORTS-1:0]      mask,
    output logic [PCNT_W-1:0]         pcnt,
    output logic [7:0]                mpw
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_BYTES - 1);

    typedef struct packed {
        ld_state_e                 st;
        logic [IDX_W-1:0]          idx;
        logic [IMG_BYTES-1:0][7:0] img;
        logic                      vld;
        logic                      dn;
        logic [15:0]               vid;
        logic [15:0]               pid;
        logic [NUM_PORTS-1:0]      mask;
        logic [PCNT_W-1:0]         pcnt;
        logic [7:0]                mpw;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_REQ: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (rd_rvalid) begin
                    for (int i = 0; i < IMG_BYTES; i++) begin
                        if (r_q.idx == IDX_W'(i)) r_d.img[i] = rd_rdata;
                    end
                    if (r_q.idx == LAST_IDX) begin
                        r_d.st = ST_DECIDE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_REQ;
                    end
                end
            end
            ST_DECIDE: begin
                r_d.vld  = chk_accept;
                r_d.vid  = chk_vid;
                r_d.pid  = chk_pid;
                r_d.mask = chk_mask;
                r_d.pcnt = chk_pcnt;
                r_d.mpw  = chk_mpw;
                r_d.st   = ST_DONE;
            end
            ST_DONE: r_d.dn = 1'b1;
            default: r_d.st = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_REQ;
            r_q.idx  <= '0;
            r_q.img  <= '0;
            r_q.vld  <= 1'b0;
            r_q.dn   <= 1'b0;
            r_q.vid  <= DEF_VID;
            r_q.pid  <= DEF_PID;
            r_q.mask <= '0;
            r_q.pcnt <= PCNT_W'(NUM_PORTS);
            r_q.mpw  <= DEF_MAX_PWR;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req    = (r_q.st == ST_REQ);
    assign rd_idx    = r_q.idx;
    assign img       = r_q.img;
    assign cfg_valid = r_q.vld;
    assign ld_done   = r_q.dn;
    assign vid       = r_q.vid;
    assign pid       = r_q.pid;
    assign mask      = r_q.mask;
    assign pcnt      = r_q.pcnt;
    assign mpw       = r_q.mpw;

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REQ && $past(r_q.st) == ST_WAIT) |-> (r_q.idx == $past(r_q.idx) + 1'b1));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.dn |=> r_q.dn);

    assert_fields_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.dn |=> ($stable(r_q.vld) && $stable(r_q.vid) && $stable(r_q.pid)
                    && $stable(r_q.mask) && $stable(r_q.pcnt) && $stable(r_q.mpw)));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int          NUM_PORTS     = 4,
    parameter int          ADDR_W        = 8,
    parameter logic [15:0] DEF_VID       = 16'h04B4,
    parameter logic [15:0] DEF_PID       = 16'h6570,
    parameter logic [7:0]  DEF_MAX_PWR   = 8'h32,
    parameter logic [7:0]  MAX_PWR_LIMIT = 8'hFA,
    parameter int          PCNT_W        = $clog2(NUM_PORTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 ee_req,
    output logic [ADDR_W-1:0]    ee_addr,
    input  logic                 ee_rvalid,
    input  logic [7:0]           ee_rdata,
    input  logic                 pt_req,
    input  logic [ADDR_W-1:0]    pt_addr,
    output logic                 pt_rvalid,
    output logic [7:0]           pt_rdata,
    output logic                 config_valid,
    output logic                 done,
    output logic [15:0]          vendor_id,
    output logic [15:0]          product_id,
    output logic [NUM_PORTS-1:0] fixed_mask,
    output logic [PCNT_W-1:0]    port_count,
    output logic [7:0]           max_power
);
    localparam int IDX_W = $clog2(IMG_BYTES);

    logic                      ld_req;
    logic [IDX_W-1:0]          ld_idx;
    logic [IMG_BYTES-1:0][7:0] img;
    logic                      c_accept;
    logic [15:0]               c_vid, c_pid;
    logic [NUM_PORTS-1:0]      c_mask;
    logic [PCNT_W-1:0]         c_pcnt;
    logic [7:0]                c_mpw;
    logic                      out_q;

    cfg_loader_seq #(
        .NUM_PORTS(NUM_PORTS), .IMG_BYTES(IMG_BYTES), .IDX_W(IDX_W), .PCNT_W(PCNT_W),
        .DEF_VID(DEF_VID), .DEF_PID(DEF_PID), .DEF_MAX_PWR(DEF_MAX_PWR)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .rd_rvalid(ee_rvalid && !done), .rd_rdata(ee_rdata),
        .rd_req(ld_req), .rd_idx(ld_idx), .img(img),
        .chk_accept(c_accept), .chk_vid(c_vid), .chk_pid(c_pid),
        .chk_mask(c_mask), .chk_pcnt(c_pcnt), .chk_mpw(c_mpw),
        .cfg_valid(config_valid), .ld_done(done),
        .vid(vendor_id), .pid(product_id), .mask(fixed_mask),
        .pcnt(port_count), .mpw(max_power)
    );

    cfg_image_check #(
        .NUM_PORTS(NUM_PORTS), .IMG_BYTES(IMG_BYTES), .PCNT_W(PCNT_W),
        .MAX_PWR_LIMIT(MAX_PWR_LIMIT), .DEF_VID(DEF_VID), .DEF_PID(DEF_PID),
        .DEF_MAX_PWR(DEF_MAX_PWR)
    ) u_check (
        .img(img), .accept(c_accept), .vid(c_vid), .pid(c_pid),
        .mask(c_mask), .pcnt(c_pcnt), .mpw(c_mpw)
    );

    // request channel owner: loader until done, pass-through afterwards
    assign ee_req    = done ? pt_req  : ld_req;
    assign ee_addr   = done ? pt_addr : ADDR_W'(ld_idx);
    assign pt_rvalid = done && ee_rvalid;
    assign pt_rdata  = ee_rdata;

    // outstanding-request tracker used only by the checks below
    always_ff @(posedge clk) begin
        if (!rst_n)         out_q <= 1'b0;
        else if (ee_rvalid) out_q <= 1'b0;
        else if (ee_req)    out_q <= 1'b1;
    end

    assert_single_outstanding_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req |-> !out_q);

    assert_accept_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && config_valid) |-> (port_count != '0 && port_count <= PCNT_W'(NUM_PORTS)
                                    && max_power <= MAX_PWR_LIMIT));

    assert_default_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !config_valid) |-> (vendor_id == DEF_VID && product_id == DEF_PID
                                     && fixed_mask == '0 && max_power == DEF_MAX_PWR));

endmodule

// File: tb/cfg_loader_tb.sv
`timescale 1ns/1ps
module cfg_loader_tb;
    localparam int         NP     = 4;
    localparam int         PW     = $clog2(NP + 1);
    localparam logic [7:0] DEF_MP = 8'h32;

    typedef logic [8:0][7:0] img_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ee_req;
    logic [7:0]    ee_addr;
    logic          ee_rvalid = 1'b0;
    logic [7:0]    ee_rdata = 8'h00;
    logic          pt_req = 1'b0;
    logic [7:0]    pt_addr = 8'h00;
    logic          pt_rvalid;
    logic [7:0]    pt_rdata;
    logic          config_valid, done;
    logic [15:0]   vendor_id, product_id;
    logic [NP-1:0] fixed_mask;
    logic [PW-1:0] port_count;
    logic [7:0]    max_power;

    always #2 clk = ~clk;

    cfg_loader #(.NUM_PORTS(NP), .DEF_MAX_PWR(DEF_MP)) u_dut (
        .clk(clk), .rst_n(rst_n), .ee_req(ee_req), .ee_addr(ee_addr),
        .ee_rvalid(ee_rvalid), .ee_rdata(ee_rdata), .pt_req(pt_req), .pt_addr(pt_addr),
        .pt_rvalid(pt_rvalid), .pt_rdata(pt_rdata), .config_valid(config_valid),
        .done(done), .vendor_id(vendor_id), .product_id(product_id),
        .fixed_mask(fixed_mask), .port_count(port_count), .max_power(max_power)
    );

    logic [7:0] mem [256];
    logic [7:0] req_log [64];
    int total = 0, bad = 0;
    int nreq = 0, overlap = 0, early_pt = 0;
    bit pend = 1'b0;
    int cnt = 0;
    logic [7:0] cur_addr = 8'h00;

    // EEPROM model: one reply per request, 1..4 cycles later
    always @(posedge clk) begin
        if (!rst_n) begin
            pend = 1'b0;
            ee_rvalid <= 1'b0;
        end else begin
            ee_rvalid <= 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    ee_rvalid <= 1'b1;
                    ee_rdata  <= mem[cur_addr];
                    pend = 1'b0;
                end else begin
                    cnt--;
                end
            end
            if (ee_req) begin
                if (pend) overlap++;
                pend = 1'b1;
                cnt = $urandom_range(0, 3);
                cur_addr = ee_addr;
                if (nreq < 64) req_log[nreq] = ee_addr;
                nreq++;
            end
            if (pt_rvalid && !done) early_pt++;
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic bit exp_accept(input img_t b);
        logic [7:0] s;
        s = b[0] + b[1] + b[2] + b[3] + 8'd1;
        return (b[4] == s) && (b[7] >= 8'd1) && (b[7] <= 8'(NP)) && (b[8] <= 8'hFA);
    endfunction

    function automatic img_t mk(input logic [7:0] v0, v1, p0, p1, fx, pc, mp, input bit good);
        img_t b;
        b[0] = v0; b[1] = v1; b[2] = p0; b[3] = p1;
        b[4] = v0 + v1 + p0 + p1 + (good ? 8'd1 : 8'd2);
        b[5] = 8'hFF; b[6] = fx; b[7] = pc; b[8] = mp;
        return b;
    endfunction

    task automatic run_image(input img_t im, input bit poke);
        bit         acc;
        logic       prev_cv;
        logic [15:0] prev_vid, prev_pid;
        logic [7:0]  prev_mp;
        int         guard;
        for (int i = 0; i < 9; i++) mem[i] = im[i];
        @(negedge clk);
        rst_n = 1'b0;
        pt_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7", "reset done/valid", {30'd0, done, config_valid}, 32'd0);
        nreq = 0; overlap = 0; early_pt = 0;
        rst_n = 1'b1;
        prev_cv = config_valid; prev_vid = vendor_id; prev_pid = product_id; prev_mp = max_power;
        if (poke) begin
            @(negedge clk);
            pt_req = 1'b1; pt_addr = 8'h40;
            @(negedge clk);
            pt_req = 1'b0;
        end
        guard = 0;
        forever begin
            @(negedge clk);
            if (done || guard > 400) break;
            prev_cv = config_valid; prev_vid = vendor_id; prev_pid = product_id; prev_mp = max_power;
            guard++;
        end
        acc = exp_accept(im);
        chk("R2", "config_valid", {31'd0, config_valid}, {31'd0, acc});
        if (acc) begin
            chk("R3", "vendor_id", {16'd0, vendor_id}, {16'd0, im[1], im[0]});
            chk("R3", "product_id", {16'd0, product_id}, {16'd0, im[3], im[2]});
            chk("R4", "fixed_mask", 32'(fixed_mask), 32'(im[6][4:1]));
            chk("R5", "port_count", 32'(port_count), 32'(im[7]));
            chk("R5", "max_power", 32'(max_power), 32'(im[8]));
        end else begin
            chk("R6", "vendor_id", {16'd0, vendor_id}, 32'h04B4);
            chk("R6", "product_id", {16'd0, product_id}, 32'h6570);
            chk("R6", "fixed_mask", 32'(fixed_mask), 32'd0);
            chk("R6", "port_count", 32'(port_count), 32'(NP));
            chk("R6", "max_power", 32'(max_power), 32'(DEF_MP));
        end
        chk("R1", "request count", 32'(nreq), 32'd9);
        for (int i = 0; i < 9; i++) chk("R1", "request order", 32'(req_log[i]), 32'(i));
        chk("R1", "overlapping requests", 32'(overlap), 32'd0);
        chk("R7", "valid before done", {31'd0, prev_cv}, {31'd0, config_valid});
        chk("R7", "vid before done", {16'd0, prev_vid}, {16'd0, vendor_id});
        chk("R7", "pid before done", {16'd0, prev_pid}, {16'd0, product_id});
        chk("R7", "power before done", 32'(prev_mp), 32'(max_power));
        chk("R8", "early pt_rvalid", 32'(early_pt), 32'd0);
    endtask

    task automatic pt_read(input logic [7:0] a);
        int n0, g;
        mem[a] = 8'($urandom);
        n0 = nreq;
        @(negedge clk);
        pt_req = 1'b1; pt_addr = a;
        @(negedge clk);
        pt_req = 1'b0;
        g = 0;
        while (!pt_rvalid && g < 20) begin
            @(negedge clk);
            g++;
        end
        chk("R8", "pt_rvalid", {31'd0, pt_rvalid}, 32'd1);
        chk("R8", "pt_rdata", 32'(pt_rdata), 32'(mem[a]));
        chk("R8", "pt request addr", 32'(req_log[n0]), 32'(a));
        chk("R8", "pt request count", 32'(nreq - n0), 32'd1);
    endtask

    initial begin
        repeat (500000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        // directed corners
        run_image(mk(8'h34, 8'h12, 8'h78, 8'h56, 8'h1E, 8'd4, 8'd64, 1'b1), 1'b0);   // R2 R3 accept
        run_image(mk(8'h34, 8'h12, 8'h78, 8'h56, 8'h1E, 8'd4, 8'd64, 1'b0), 1'b0);   // R6 bad checksum
        run_image(mk(8'h01, 8'h02, 8'h03, 8'h04, 8'h02, 8'd0, 8'd10, 1'b1), 1'b0);   // R2 port count 0
        run_image(mk(8'h01, 8'h02, 8'h03, 8'h04, 8'h02, 8'd5, 8'd10, 1'b1), 1'b0);   // R2 port count 5
        run_image(mk(8'hAA, 8'h55, 8'h0F, 8'hF0, 8'h10, 8'd1, 8'd10, 1'b1), 1'b0);   // R5 port count 1
        run_image(mk(8'h11, 8'h22, 8'h33, 8'h44, 8'h04, 8'd3, 8'hFA, 1'b1), 1'b0);   // R5 power at limit
        run_image(mk(8'h11, 8'h22, 8'h33, 8'h44, 8'h04, 8'd3, 8'hFB, 1'b1), 1'b0);   // R2 power over limit
        run_image(mk(8'h9C, 8'h03, 8'h21, 8'h43, 8'hE1, 8'd2, 8'd50, 1'b1), 1'b0);   // R4 reserved bits
        run_image(mk(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h0A, 8'd4, 8'd0, 1'b1), 1'b0);    // R2 sum wraps
        run_image(mk(8'h21, 8'h43, 8'h65, 8'h87, 8'h08, 8'd2, 8'd20, 1'b1), 1'b1);   // R8 pt ignored
        pt_read(8'h45);
        pt_read(8'h72);
        // random images
        for (int n = 0; n < 40; n++) begin
            logic [7:0] pc, mp;
            bit good;
            pc = 8'($urandom_range(0, 5));
            mp = ($urandom_range(0, 1) == 1) ? 8'($urandom_range(0, 250)) : 8'($urandom_range(0, 255));
            good = ($urandom_range(0, 3) != 0);
            run_image(mk(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                         8'($urandom), pc, mp, good), ($urandom_range(0, 3) == 0));
            if (n % 8 == 0) pt_read(8'($urandom_range(16, 255)));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule